// File: doc/BRIEF.md
# LIN Slave Auto-Baud Synchronizer

This block lets a LIN slave lock its bit rate to the master. After each synch break, it times the synch byte (0x55) that follows on the receive line. It turns the cycle count into a fixed-point baud divider and drives a 16x oversampling tick from that divider. The same tick serves the transmitter and the receiver.

Three divider registers sit inside the block:
- a nominal value, written by software;
- a measured value, captured from the synch field;
- an active value, which drives the tick.

An update-method input chooses how a new measurement reaches the active divider. In immediate mode it is applied as soon as the measurement ends. In deferred mode it is held until the next break or the next software write.

While a measurement is running, a busy flag tells the serial receiver to halt.

Break detection, character framing, identifier parsing and checksum handling are outside this block. The break is given to the block as a one-cycle input pulse.

Top module: `lin_autobaud`

## Requirements
- R1: After reset, the active divider is 0x100 (mantissa 16, fraction 0), the busy flag is low and the baud tick is low.
- R2: A software write of the nominal divider loads both the nominal and the active divider at the next clock edge. In the written word, bits 11:4 are the mantissa and bits 3:0 are the fraction. The active divider changes only on a write, at the end of a measurement, or on a break that releases a pending measurement.
- R3: When auto-sync is enabled, a break pulse raises the busy flag on the next cycle. The flag stays high until the fifth falling edge of the receive line ends the measurement, or until the measurement is abandoned.
- R4: Let N be the number of clock cycles from the first falling edge of the receive line to the fifth. The measured divider, in 1/16 units, is floor(N/8).
- R5: In immediate mode (update select low), the measured divider becomes the active divider one cycle after the busy flag falls.
- R6: In deferred mode (update select high), the end of a measurement leaves the active divider unchanged. The next break pulse then loads the held measured value into the active divider. This happens whether or not auto-sync is enabled.
- R7: A software write discards any held measurement. When a write and a measured-value transfer reach the active divider in the same cycle, the written value wins.
- R8: A break pulse while auto-sync is disabled starts no measurement. The busy flag stays low, and the active divider is unchanged when no measurement is being held.
- R9: A break pulse that arrives before the fifth falling edge discards the partial count and restarts the measurement.
- R10: If the 15-bit cycle count reaches 32767 before the fifth falling edge, the measurement is abandoned. The busy flag drops and the active divider is unchanged.
- R11: With an active divider D of at least 16, the tick averages 16/D ticks per clock cycle. Over any window of L cycles in which D stays constant, the tick count differs from 16L/D by less than one.
- R12: With an active divider below 16, the tick is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | LIN receive line, idle high |
| brk_det_i | input | 1 | One-cycle pulse: synch break detected |
| auto_en_i | input | 1 | Enable automatic resynchronization |
| upd_defer_i | input | 1 | Update method: 0 immediate, 1 deferred |
| nom_we_i | input | 1 | Write strobe for the nominal divider |
| nom_wdata_i | input | 12 | Nominal divider: mantissa in bits 11:4, fraction in bits 3:0 |
| div_mant_o | output | 8 | Active divider, integer part |
| div_frac_o | output | 4 | Active divider, fractional part |
| meas_busy_o | output | 1 | Synch field measurement in progress; halts the receiver |
| baud_tick_o | output | 1 | 16x oversampling baud tick |

## Verification
The assertions assume three things about the inputs:
- the break input is a single-cycle pulse;
- the receive line is asynchronous and is seen only through the internal synchronizer;
- the write strobe carries valid data whenever it is high.

The stimulus follows these rules. Inputs change only on the falling clock edge, and every break is a one-cycle pulse. Synch fields are built bit by bit from whole-cycle bit times, with extra cycles added only to the bit before the fifth falling edge, so the expected count is exact. The overflow case holds the line high after a single falling edge until the counter saturates.

// File: rtl/lin_ab_pkg.sv
package lin_ab_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARMED = 2'd1,
    MS_RUN   = 2'd2
  } meas_state_e;
endpackage

// File: rtl/lin_sync_meas.sv
module lin_sync_meas
  import lin_ab_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int EDGES = 5,
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             brk_i,
  input  logic             en_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DIV_W-1:0] val_o
);
  // edges span 2*(EDGES-1) bit times; a bit lasts 16 units of 1/16
  localparam int SHIFT  = $clog2(2 * (EDGES - 1));
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam int RES_W  = CNT_W - SHIFT;

  meas_state_e      state_q;
  logic [2:0]       rx_pipe_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EDGE_W-1:0] edges_q;
  logic             done_q;
  logic [DIV_W-1:0] val_q;
  logic             fall;
  logic             last_edge;
  logic             cnt_full;
  logic [RES_W-1:0] scaled;
  logic [DIV_W-1:0] val_next;

  assign fall      = rx_pipe_q[2] & ~rx_pipe_q[1];
  assign last_edge = fall && (edges_q == EDGE_W'(EDGES - 1));
  assign cnt_full  = (cnt_q == {CNT_W{1'b1}});
  assign scaled    = cnt_q[CNT_W-1:SHIFT];

  generate
    if (RES_W > DIV_W) begin : g_sat
      assign val_next = (|scaled[RES_W-1:DIV_W]) ? {DIV_W{1'b1}} : scaled[DIV_W-1:0];
    end else if (RES_W == DIV_W) begin : g_exact
      assign val_next = scaled;
    end else begin : g_pad
      assign val_next = {{(DIV_W - RES_W){1'b0}}, scaled};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_pipe_q <= 3'b111;
    end else begin
      rx_pipe_q <= {rx_pipe_q[1:0], rx_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_IDLE;
      cnt_q   <= '0;
      edges_q <= '0;
      done_q  <= 1'b0;
      val_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (brk_i && en_i) begin
        state_q <= MS_ARMED;
        cnt_q   <= '0;
        edges_q <= '0;
      end else begin
        unique case (state_q)
          MS_ARMED: begin
            if (fall) begin
              state_q <= MS_RUN;
              cnt_q   <= CNT_W'(1);
              edges_q <= EDGE_W'(1);
            end
          end
          MS_RUN: begin
            if (last_edge) begin
              state_q <= MS_IDLE;
              done_q  <= 1'b1;
              val_q   <= val_next;
            end else if (cnt_full) begin
              state_q <= MS_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
              if (fall) edges_q <= edges_q + EDGE_W'(1);
            end
          end
          default: state_q <= MS_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != MS_IDLE);
  assign done_o = done_q;
  assign val_o  = val_q;
endmodule

// File: rtl/lin_div_bank.sv
module lin_div_bank #(
  parameter int DIV_W   = 12,
  parameter int NOM_RST = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DIV_W-1:0] wdata_i,
  input  logic             done_i,
  input  logic [DIV_W-1:0] meas_i,
  input  logic             defer_i,
  input  logic             brk_i,
  output logic [DIV_W-1:0] act_o
);
  localparam logic [DIV_W-1:0] RST_V = DIV_W'(NOM_RST);

  logic [DIV_W-1:0] nom_q;
  logic [DIV_W-1:0] meas_q;
  logic             pend_q;
  logic [DIV_W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nom_q  <= RST_V;
      meas_q <= RST_V;
      pend_q <= 1'b0;
      act_q  <= RST_V;
    end else if (we_i) begin
      // software write wins over any measured transfer
      nom_q  <= wdata_i;
      act_q  <= wdata_i;
      pend_q <= 1'b0;
    end else begin
      if (brk_i && pend_q) begin
        act_q  <= meas_q;
        pend_q <= 1'b0;
      end
      if (done_i) begin
        meas_q <= meas_i;
        if (defer_i) begin
          pend_q <= 1'b1;
        end else begin
          act_q  <= meas_i;
          pend_q <= 1'b0;
        end
      end
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/lin_baud_acc.sv
module lin_baud_acc #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int ACC_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] OVS_D = DIV_W'(OVS);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] div_eff;
  logic             hit;
  logic             tick_q;

  // divider below one bit-sample period clamps to one tick per clock
  assign div_eff = {1'b0, (div_i < OVS_D) ? OVS_D : div_i};
  assign sum     = acc_q + ACC_W'(OVS);
  assign hit     = (sum >= div_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= hit;
      acc_q  <= hit ? (sum - div_eff) : sum;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud #(
  parameter int MANT_W  = 8,
  parameter int FRAC_W  = 4,
  parameter int CNT_W   = 15,
  parameter int EDGES   = 5,
  parameter int OVS     = 16,
  parameter int NOM_RST = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              brk_det_i,
  input  logic              auto_en_i,
  input  logic              upd_defer_i,
  input  logic              nom_we_i,
  input  logic [MANT_W+FRAC_W-1:0] nom_wdata_i,
  output logic [MANT_W-1:0] div_mant_o,
  output logic [FRAC_W-1:0] div_frac_o,
  output logic              meas_busy_o,
  output logic              baud_tick_o
);
  localparam int DIV_W = MANT_W + FRAC_W;

  logic             meas_done;
  logic [DIV_W-1:0] meas_val;
  logic [DIV_W-1:0] div_act;

  lin_sync_meas #(
    .CNT_W(CNT_W),
    .EDGES(EDGES),
    .DIV_W(DIV_W)
  ) i_meas (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .brk_i (brk_det_i),
    .en_i  (auto_en_i),
    .busy_o(meas_busy_o),
    .done_o(meas_done),
    .val_o (meas_val)
  );

  lin_div_bank #(
    .DIV_W  (DIV_W),
    .NOM_RST(NOM_RST)
  ) i_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (nom_we_i),
    .wdata_i(nom_wdata_i),
    .done_i (meas_done),
    .meas_i (meas_val),
    .defer_i(upd_defer_i),
    .brk_i  (brk_det_i),
    .act_o  (div_act)
  );

  lin_baud_acc #(
    .DIV_W(DIV_W),
    .OVS  (OVS)
  ) i_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .div_i (div_act),
    .tick_o(baud_tick_o)
  );

  assign div_mant_o = div_act[DIV_W-1:FRAC_W];
  assign div_frac_o = div_act[FRAC_W-1:0];
endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk #(
  parameter int DIV_W = 12,
  parameter int OVS   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             brk_det_i,
  input logic             auto_en_i,
  input logic             upd_defer_i,
  input logic             nom_we_i,
  input logic [DIV_W-1:0] nom_wdata_i,
  input logic [DIV_W-1:0] div_act,
  input logic             meas_busy_o,
  input logic             baud_tick_o,
  input logic             meas_done,
  input logic [DIV_W-1:0] meas_val
);
  AST_BREAK_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i && brk_det_i |=> meas_busy_o); // R3

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_done |-> !meas_busy_o); // R3

  AST_OFF_BREAK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i && brk_det_i && !meas_busy_o |=> !meas_busy_o); // R8

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nom_we_i |=> div_act == $past(nom_wdata_i)); // R7

  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nom_we_i && !meas_done && !brk_det_i |=> $stable(div_act)); // R2

  AST_IMM_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_defer_i && meas_done && !nom_we_i |=> div_act == $past(meas_val)); // R5

  AST_DEFER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_defer_i && meas_done && !nom_we_i && !brk_det_i |=> $stable(div_act)); // R6

  AST_FAST_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_act < DIV_W'(OVS) |=> baud_tick_o); // R12
endmodule

bind lin_autobaud lin_autobaud_chk #(
  .DIV_W(DIV_W),
  .OVS  (OVS)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .brk_det_i  (brk_det_i),
  .auto_en_i  (auto_en_i),
  .upd_defer_i(upd_defer_i),
  .nom_we_i   (nom_we_i),
  .nom_wdata_i(nom_wdata_i),
  .div_act    (div_act),
  .meas_busy_o(meas_busy_o),
  .baud_tick_o(baud_tick_o),
  .meas_done  (meas_done),
  .meas_val   (meas_val)
);

// File: tb/test_lin_autobaud.sv
`timescale 1ns/1ps
module test_lin_autobaud;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx = 1'b1;
  logic        brk = 1'b0;
  logic        auto_en = 1'b0;
  logic        defer = 1'b0;
  logic        we = 1'b0;
  logic [11:0] wd = '0;
  logic [7:0]  mant;
  logic [3:0]  frac;
  logic        busy;
  logic        tick;
  logic [11:0] act;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_q[$];

  always #4 clk = ~clk;

  lin_autobaud i_lin_autobaud (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .rx_i       (rx),
    .brk_det_i  (brk),
    .auto_en_i  (auto_en),
    .upd_defer_i(defer),
    .nom_we_i   (we),
    .nom_wdata_i(wd),
    .div_mant_o (mant),
    .div_frac_o (frac),
    .meas_busy_o(busy),
    .baud_tick_o(tick)
  );

  assign act = {mant, frac};

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic wr_nom(logic [11:0] v);
    @(negedge clk); we = 1'b1; wd = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk); brk = 1'b1;
    @(negedge clk); brk = 1'b0;
  endtask

  // 0x55 framed: start, LSB first, stop; extra cycles go to the bit before the 5th fall
  task automatic send_field(int b, int extra, bit push, logic [11:0] exp);
    logic lv [10] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    if (push) exp_q.push_back(exp);
    for (int i = 0; i < 10; i++) begin
      rx = lv[i];
      repeat (b + ((i == 7) ? extra : 0)) @(negedge clk);
    end
    rx = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic count_ticks(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
  endtask

  // monitor: on each busy fall, active divider one cycle later must match the scoreboard
  initial begin
    logic prev = 1'b0;
    logic [11:0] e;
    forever begin
      @(negedge clk);
      if (prev && !busy) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4/R5 unexpected measurement end got %0h exp none", act);
        end else begin
          e = exp_q.pop_front();
          chk("R4/R5/R6/R10 divider after measurement", act, e);
        end
        prev = busy;
      end else begin
        prev = busy;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired got running exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset divider", act, 12'h100);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset tick", tick, 0);

    wr_nom(12'h0A8);
    chk("R2 nominal write", act, 12'h0A8);
    chk("R2 fields", {mant, frac}, {8'h0A, 4'h8});

    auto_en = 1'b1;
    pulse_brk();
    chk("R3 busy after break", busy, 1);
    repeat (3) @(negedge clk);
    send_field(20, 0, 1'b1, 12'd20);          // R4 R5
    pulse_brk();
    send_field(37, 3, 1'b1, 12'd37);          // R4 truncation
    pulse_brk();
    send_field(37, 9, 1'b1, 12'd38);          // R4 carry into next unit

    // R9: partial field then a new break
    pulse_brk();
    rx = 1'b0; repeat (30) @(negedge clk);
    rx = 1'b1; repeat (30) @(negedge clk);
    rx = 1'b0; repeat (30) @(negedge clk);
    rx = 1'b1; repeat (30) @(negedge clk);
    pulse_brk();
    chk("R9 busy kept by restart", busy, 1);
    send_field(25, 0, 1'b1, 12'd25);

    // R8
    auto_en = 1'b0;
    pulse_brk();
    chk("R8 busy stays low", busy, 0);
    send_field(30, 0, 1'b0, 12'd0);
    chk("R8 busy low after field", busy, 0);
    chk("R8 divider unchanged", act, 12'd25);

    // R10: single fall then a quiet line until the count saturates
    auto_en = 1'b1;
    pulse_brk();
    exp_q.push_back(12'd25);
    rx = 1'b0; repeat (10) @(negedge clk);
    rx = 1'b1;
    repeat (32800) @(negedge clk);
    chk("R10 busy dropped on overflow", busy, 0);
    chk("R10 divider unchanged", act, 12'd25);

    // R6 deferred
    defer = 1'b1;
    pulse_brk();
    send_field(30, 0, 1'b1, 12'd25);
    auto_en = 1'b0;
    pulse_brk();
    chk("R6 deferred load on break", act, 12'd30);

    // R7 write discards pending
    auto_en = 1'b1;
    pulse_brk();
    send_field(44, 0, 1'b1, 12'd30);
    auto_en = 1'b0;
    wr_nom(12'h050);
    chk("R7 write loads", act, 12'h050);
    pulse_brk();
    chk("R7 pending discarded", act, 12'h050);

    // R7 same-cycle priority
    auto_en = 1'b1;
    pulse_brk();
    send_field(50, 0, 1'b1, 12'h050);
    auto_en = 1'b0;
    @(negedge clk); brk = 1'b1; we = 1'b1; wd = 12'h0C3;
    @(negedge clk); brk = 1'b0; we = 1'b0;
    chk("R7 write beats transfer", act, 12'h0C3);

    // R11 / R12 tick rate
    defer = 1'b0;
    wr_nom(12'd40);
    repeat (3) @(negedge clk);
    count_ticks(400, n);
    chk("R11 ticks at D=40", n, 160);
    wr_nom(12'd16);
    repeat (3) @(negedge clk);
    count_ticks(100, n);
    chk("R11 ticks at D=16", n, 100);
    wr_nom(12'd5);
    repeat (3) @(negedge clk);
    count_ticks(50, n);
    chk("R12 ticks at D=5", n, 50);

    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule